// File: doc/BRIEF.md
# Four-Channel Inter-Processor Mailbox

This block carries short messages in one direction between two processors that share a chip. It has two 32-bit register windows. The sending processor uses one window and the receiving processor uses the other. There are four independent channels. Each channel owns a message buffer of eight 32-bit words. The sender fills a channel's buffer and then fires that channel's trigger bit. The channel becomes pending, and the pending state is visible in the status register of both windows.

The receiver decides which channels may raise its interrupt through a per-channel enable register. Its level interrupt is high whenever an enabled channel is pending. The receiver's service routine reads the message words through its own window, which is read-only. It then acknowledges the channel by writing a one to that channel's status bit. The sender sees the bit return to zero and knows that the buffer is free again. The receiver's enable register is mirrored, read-only, into the sender window. This lets the sender find out that nobody is listening on a channel.

Both windows are word-addressed by byte address. Reads return data in the same cycle the address is presented, and writes take effect at the next rising clock edge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, all enable bits, status bits and message words read as zero in both windows, and `irq` is low.
- R2: A sender write to byte offset 0x10 + 32*c + 4*w (channel c in 0..3, word w in 0..7) stores the word. The word reads back at the same offset in both the sender and the receiver window.
- R3: Receiver writes to any message offset have no effect on the stored words.
- R4: A sender write to offset 0x00 with bit c set, while enable bit c is 1 and status bit c is 0, sets status bit c. Status bit c reads at offset 0x08 in both windows, at bit position c.
- R5: A trigger is ignored for a channel whose enable bit is 0 or whose status bit is already 1. Writes to offset 0x00 of the receiver window do nothing. Bits 31:4 of a trigger write are ignored.
- R6: `irq` is 1 exactly when at least one channel has both its enable bit and its status bit set.
- R7: A receiver write to offset 0x08 clears every status bit whose write-data bit is 1, and leaves the other status bits unchanged.
- R8: The enable register is written at receiver offset 0x04, bit c for channel c. It reads back at offset 0x04 of both windows. Sender writes to offset 0x04 or 0x08 are ignored.
- R9: When a receiver clear and a sender trigger reach the same status bit in the same cycle, the status bit ends up 0.
- R10: Reads of offset 0x00, 0x0C, misaligned offsets, and offsets at or above 0x90 return zero in both windows. So do bits 31:4 of the enable and status registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| s_we | input | 1 | Sender window write strobe |
| s_addr | input | 8 | Sender window byte address |
| s_wdata | input | 32 | Sender window write data |
| s_rdata | output | 32 | Sender window read data for `s_addr` |
| r_we | input | 1 | Receiver window write strobe |
| r_addr | input | 8 | Receiver window byte address |
| r_wdata | input | 32 | Receiver window write data |
| r_rdata | output | 32 | Receiver window read data for `r_addr` |
| irq | output | 1 | Level interrupt to the receiver |

## Verification
The assertions assume that each write strobe is valid for exactly the cycle it is sampled. They also assume that the address and data lines hold a known value whenever their strobe is high. The bench drives every strobe for one cycle, starting at a falling edge, and it holds the address and data steady for that cycle. Some checks involve a simultaneous sender trigger and receiver clear. For those, the bench raises both strobes in the same cycle, so the priority rule is exercised at the clock edge and not through ordering in the bench.

// File: rtl/ipcmb_pkg.sv
package ipcmb_pkg;
  // Register window byte offsets (identical in both windows)
  localparam int OFS_TRIG       = 'h00;
  localparam int OFS_ENABLE     = 'h04;
  localparam int OFS_STATUS     = 'h08;
  localparam int OFS_MSG_BASE   = 'h10;
  localparam int BYTES_PER_WORD = 4;

  typedef struct packed {
    logic hit_trig;
    logic hit_enable;
    logic hit_status;
    logic hit_msg;
  } win_hit_t;
endpackage

// File: rtl/ipcmb_decode.sv
module ipcmb_decode
  import ipcmb_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic [AW-1:0] addr,
  output win_hit_t      hit,
  output logic [IW-1:0] msg_idx
);
  localparam int          SPAN     = DEPTH * BYTES_PER_WORD;
  localparam logic [AW:0] MSG_LO   = (AW+1)'(OFS_MSG_BASE);
  localparam logic [AW:0] MSG_HI   = (AW+1)'(OFS_MSG_BASE + SPAN);

  logic [AW:0]   addr_x;
  logic          aligned;
  logic [AW-1:0] msg_off;

  always_comb begin
    addr_x  = {1'b0, addr};
    aligned = (addr[1:0] == 2'b00);
    msg_off = addr - AW'(OFS_MSG_BASE);

    hit.hit_trig   = (addr == AW'(OFS_TRIG));
    hit.hit_enable = (addr == AW'(OFS_ENABLE));
    hit.hit_status = (addr == AW'(OFS_STATUS));
    hit.hit_msg    = aligned && (addr_x >= MSG_LO) && (addr_x < MSG_HI);
    msg_idx        = IW'(msg_off >> 2);
  end
endmodule

// File: rtl/ipcmb_chan_ctrl.sv
module ipcmb_chan_ctrl #(
  parameter int N_CH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_we,
  input  logic [N_CH-1:0] en_wbits,
  input  logic            trig_we,
  input  logic [N_CH-1:0] trig_bits,
  input  logic            ack_we,
  input  logic [N_CH-1:0] ack_bits,
  output logic [N_CH-1:0] en_q,
  output logic [N_CH-1:0] st_q
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic en_d, en_ce;
    logic st_d, st_ce;
    logic trig_ok, ack_hit;

    // next-state
    always_comb begin
      en_ce   = en_we;
      en_d    = en_wbits[c];
      trig_ok = trig_we && trig_bits[c] && en_q[c] && !st_q[c];
      ack_hit = ack_we && ack_bits[c];
      st_ce   = ack_hit || trig_ok;
      st_d    = ack_hit ? 1'b0 : 1'b1;
    end

    // registers
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[c] <= 1'b0;
        st_q[c] <= 1'b0;
      end else begin
        if (en_ce) en_q[c] <= en_d;
        if (st_ce) st_q[c] <= st_d;
      end
    end

    AST_TRIG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_we && trig_bits[c] && en_q[c] && !(ack_we && ack_bits[c])) |=> st_q[c]); // R4
    AST_TRIG_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[c] && !st_q[c]) |=> !st_q[c]); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && ack_bits[c]) |=> !st_q[c]); // R9
    AST_ST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ack_we && ack_bits[c]) && !(trig_we && trig_bits[c])) |=> $stable(st_q[c])); // R7
    AST_EN_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      en_we |=> (en_q[c] == $past(en_wbits[c]))); // R8
  end
endmodule

// File: rtl/ipcmb_msg_store.sv
module ipcmb_msg_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 32,
  parameter int IW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx_a,
  input  logic [IW-1:0] rd_idx_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic          ce;
    logic [DW-1:0] d;

    always_comb begin
      ce = wr_en && (wr_idx == IW'(i));
      d  = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mem_q[i] <= '0;
      else if (ce) mem_q[i] <= d;
    end

    AST_WORD_ONLY_SENDER: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IW'(i)) |=> $stable(mem_q[i])); // R3
  end

  always_comb begin
    rd_data_a = '0;
    rd_data_b = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (rd_idx_a == IW'(k)) rd_data_a = mem_q[k];
      if (rd_idx_b == IW'(k)) rd_data_b = mem_q[k];
    end
  end
endmodule

// File: rtl/ipcmb_rd_mux.sv
module ipcmb_rd_mux
  import ipcmb_pkg::*;
#(
  parameter int DW   = 32,
  parameter int N_CH = 4
) (
  input  win_hit_t        hit,
  input  logic [N_CH-1:0] en_bits,
  input  logic [N_CH-1:0] st_bits,
  input  logic [DW-1:0]   msg_word,
  output logic [DW-1:0]   rdata
);
  always_comb begin
    rdata = '0;
    if (hit.hit_enable)      rdata = DW'(en_bits);
    else if (hit.hit_status) rdata = DW'(st_bits);
    else if (hit.hit_msg)    rdata = msg_word;
  end
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import ipcmb_pkg::*;
#(
  parameter int N_CH      = 4,
  parameter int MSG_WORDS = 8,
  parameter int DW        = 32,
  parameter int AW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_we,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_wdata,
  output logic [DW-1:0] s_rdata,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          irq
);
  localparam int DEPTH = N_CH * MSG_WORDS;
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // window decode
  win_hit_t      s_hit, r_hit;
  logic [IW-1:0] s_idx, r_idx;

  ipcmb_decode #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_s_dec (
    .addr(s_addr), .hit(s_hit), .msg_idx(s_idx));
  ipcmb_decode #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_r_dec (
    .addr(r_addr), .hit(r_hit), .msg_idx(r_idx));

  // write qualifiers
  logic s_trig_we, s_msg_we, r_en_we, r_ack_we;

  always_comb begin
    s_trig_we = s_we && s_hit.hit_trig;
    s_msg_we  = s_we && s_hit.hit_msg;
    r_en_we   = r_we && r_hit.hit_enable;
    r_ack_we  = r_we && r_hit.hit_status;
  end

  logic unused_r_wdata_hi;
  assign unused_r_wdata_hi = ^r_wdata[DW-1:N_CH];

  // channel state
  logic [N_CH-1:0] en_q, st_q;

  ipcmb_chan_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .en_we    (r_en_we),
    .en_wbits (r_wdata[N_CH-1:0]),
    .trig_we  (s_trig_we),
    .trig_bits(s_wdata[N_CH-1:0]),
    .ack_we   (r_ack_we),
    .ack_bits (r_wdata[N_CH-1:0]),
    .en_q     (en_q),
    .st_q     (st_q)
  );

  // message buffers
  logic [DW-1:0] s_word, r_word;

  ipcmb_msg_store #(.DW(DW), .DEPTH(DEPTH), .IW(IW)) u_store (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (s_msg_we),
    .wr_idx   (s_idx),
    .wr_data  (s_wdata),
    .rd_idx_a (s_idx),
    .rd_idx_b (r_idx),
    .rd_data_a(s_word),
    .rd_data_b(r_word)
  );

  // read paths
  ipcmb_rd_mux #(.DW(DW), .N_CH(N_CH)) u_s_rd (
    .hit(s_hit), .en_bits(en_q), .st_bits(st_q), .msg_word(s_word), .rdata(s_rdata));
  ipcmb_rd_mux #(.DW(DW), .N_CH(N_CH)) u_r_rd (
    .hit(r_hit), .en_bits(en_q), .st_bits(st_q), .msg_word(r_word), .rdata(r_rdata));

  // interrupt
  assign irq = |(en_q & st_q);

  AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (r_en_we && r_wdata[N_CH-1:0] == '0) |=> !irq); // R6
  AST_IRQ_OFF_AFTER_FULL_ACK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (r_ack_we && (&r_wdata[N_CH-1:0])) |=> !irq); // R7
  AST_NO_ACK_NO_TRIG_IRQ_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!s_we && !r_we) |=> $stable(irq)); // R6
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        s_we, r_we;
  logic [7:0]  s_addr, r_addr;
  logic [31:0] s_wdata, r_wdata, s_rdata, r_rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;

  ipc_mailbox u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .irq(irq));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  function automatic logic [31:0] pat(int i);
    return (32'h9E37_79B9 * (i + 1)) ^ (32'(i) << 24);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic s_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); s_we = 1'b1; s_addr = a; s_wdata = d;
    @(negedge clk); s_we = 1'b0;
  endtask

  task automatic r_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); r_we = 1'b1; r_addr = a; r_wdata = d;
    @(negedge clk); r_we = 1'b0;
  endtask

  task automatic both_wr(logic [7:0] sa, logic [31:0] sd, logic [7:0] ra, logic [31:0] rd);
    @(negedge clk);
    s_we = 1'b1; s_addr = sa; s_wdata = sd;
    r_we = 1'b1; r_addr = ra; r_wdata = rd;
    @(negedge clk); s_we = 1'b0; r_we = 1'b0;
  endtask

  task automatic s_rd(logic [7:0] a, output logic [31:0] d);
    s_addr = a; #1; d = s_rdata;
  endtask

  task automatic r_rd(logic [7:0] a, output logic [31:0] d);
    r_addr = a; #1; d = r_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_all_zero(string req);
    logic [31:0] v;
    s_rd(8'h04, v); check(req, v, 0);
    r_rd(8'h04, v); check(req, v, 0);
    s_rd(8'h08, v); check(req, v, 0);
    r_rd(8'h08, v); check(req, v, 0);
    check(req, {31'b0, irq}, 0);
    for (int i = 0; i < 32; i++) begin
      s_rd(8'(16 + 4*i), v); check(req, v, 0);
      r_rd(8'(16 + 4*i), v); check(req, v, 0);
    end
  endtask

  initial begin
    logic [31:0] v, exp_st;
    s_we = 0; r_we = 0; s_addr = 0; r_addr = 0; s_wdata = 0; r_wdata = 0;
    do_reset();

    // R1: reset state
    check_all_zero("R1 reset state");

    // R2: sender writes every message word, both windows read it
    for (int i = 0; i < 32; i++) s_wr(8'(16 + 4*i), pat(i));
    for (int i = 0; i < 32; i++) begin
      s_rd(8'(16 + 4*i), v); check("R2 sender readback", v, pat(i));
      r_rd(8'(16 + 4*i), v); check("R2 receiver view", v, pat(i));
    end

    // R3: receiver writes to message words ignored
    for (int i = 0; i < 32; i++) r_wr(8'(16 + 4*i), ~pat(i));
    for (int i = 0; i < 32; i++) begin
      r_rd(8'(16 + 4*i), v); check("R3 receiver write ignored", v, pat(i));
    end

    // R10: undefined offsets read zero
    foreach (v[k]) ; // no-op placeholder loop avoided below
    begin
      logic [7:0] undef_list [6] = '{8'h00, 8'h0C, 8'h11, 8'h90, 8'hA0, 8'hFC};
      for (int k = 0; k < 6; k++) begin
        s_rd(undef_list[k], v); check("R10 sender undefined", v, 0);
        r_rd(undef_list[k], v); check("R10 receiver undefined", v, 0);
      end
    end

    // R4 R5 R6 R7 R8: sweep enable x trigger, then partial clear
    for (int en = 0; en < 16; en++) begin
      for (int tg = 0; tg < 16; tg++) begin
        r_wr(8'h04, 32'hFFFF_FFF0 | 32'(en));
        r_wr(8'h08, 32'hF);
        s_wr(8'h00, 32'hFFFF_FFF0 | 32'(tg));
        exp_st = 32'(en & tg);
        s_rd(8'h08, v); check("R4 sender status", v, exp_st);
        r_rd(8'h08, v); check("R4 receiver status", v, exp_st);
        check("R6 irq", {31'b0, irq}, {31'b0, exp_st != 0});
        s_rd(8'h04, v); check("R8 enable mirror", v, 32'(en));
        r_rd(8'h04, v); check("R8 enable readback", v, 32'(en));
        begin
          int ak = (tg * 5 + en) & 15;
          r_wr(8'h08, 32'(ak));
          exp_st = exp_st & ~32'(ak);
          r_rd(8'h08, v); check("R7 partial clear", v, exp_st);
          check("R6 irq after clear", {31'b0, irq}, {31'b0, exp_st != 0});
        end
      end
    end

    // R5: trigger on already pending channel ignored; then single clear works
    r_wr(8'h04, 32'hF);
    r_wr(8'h08, 32'hF);
    s_wr(8'h00, 32'h5);
    s_wr(8'h00, 32'h5);
    s_rd(8'h08, v); check("R5 retrigger pending", v, 32'h5);
    r_wr(8'h08, 32'h1);
    s_rd(8'h08, v); check("R7 clear one", v, 32'h4);

    // R5: receiver trigger offset write does nothing
    r_wr(8'h00, 32'hF);
    s_rd(8'h08, v); check("R5 receiver trigger ignored", v, 32'h4);

    // R6: disabling keeps status, drops irq
    r_wr(8'h04, 32'h0);
    r_rd(8'h08, v); check("R6 status kept when disabled", v, 32'h4);
    check("R6 irq low when disabled", {31'b0, irq}, 0);
    r_wr(8'h04, 32'h4);
    check("R6 irq back on enable", {31'b0, irq}, 1);

    // R8: sender writes to enable/status ignored
    s_wr(8'h04, 32'h0);
    s_wr(8'h08, 32'hF);
    r_rd(8'h04, v); check("R8 sender enable write ignored", v, 32'h4);
    r_rd(8'h08, v); check("R8 sender status write ignored", v, 32'h4);

    // R9: same-cycle trigger and clear
    r_wr(8'h04, 32'hF);
    r_wr(8'h08, 32'hF);
    both_wr(8'h00, 32'h3, 8'h08, 32'h1);
    s_rd(8'h08, v); check("R9 clear beats trigger", v, 32'h2);
    both_wr(8'h00, 32'h2, 8'h08, 32'h2);
    s_rd(8'h08, v); check("R9 clear beats trigger on pending", v, 32'h0);

    // R1: reset mid-run clears everything
    s_wr(8'h00, 32'hF);
    check("R1 irq before reset", {31'b0, irq}, 1);
    do_reset();
    check_all_zero("R1 reset after activity");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule